// File: doc/BRIEF.md
# Synchronous Dual-Port RAM Core

This block is a two-port static memory in which each port runs on its own clock and has its own registered address, control and write data. Either port may read or write any word in any cycle, independently of the other. Storage is held as two banks, one written by each port; the value of a word is the bitwise XOR of the two banks at that address. This lets each port own the write side of its bank without sharing a write port with the other clock.

Every port has a run-time latency select. In flow-through mode the read word is presented in the cycle in which its address was captured. In pipelined mode a further output register adds one clock of latency. A pair of chip enables (one active low, one active high) must both be in their active state for the port to be selected. When a port is deselected it performs no write and its outputs fall idle. In pipelined mode, one selected cycle is needed before the outputs carry data again. A registered output enable and two byte-lane write enables complete the port.

Top module: `dpr_core`

## Requirements
- R1: A word written by either port is returned by a later read of that address on either port, and both ports can access different words in the same cycle.
- R2: With the mode input at 0 (flow-through), a read captured at clock edge k drives the read data and a high valid flag after edge k, until edge k+1.
- R3: With the mode input at 1 (pipelined), a read captured at edge k drives the read data and a high valid flag after edge k+1, one clock later than flow-through.
- R4: A port is selected only in a cycle with the active-low enable at 0 and the active-high enable at 1; in any other cycle its write is dropped and its read produces no valid output.
- R5: In pipelined mode, after deselected cycles the outputs stay idle until one clock after the first selected read is captured.
- R6: Lane-enable bit 0 gates the lower half of the word and bit 1 gates the upper half; a half whose bit is 0 keeps its stored value.
- R7: The output enable is captured with the address; a read captured with it low produces an idle output, while a write captured with it low still stores.
- R8: A write cycle produces no valid output on its own port.
- R9: A read on one port captured in the same edge as a write to that address on the other port returns the old word; a read captured one edge later returns the new word.
- R10: After both ports write the same address in one cycle the word is undefined, and a later write by one port alone leaves a defined value.
- R11: Whenever the valid flag is low, including during and right after reset, the read data is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A asynchronous active-low reset |
| a_en0_n | input | 1 | Port A enable, active low |
| a_en1 | input | 1 | Port A enable, active high |
| a_oe | input | 1 | Port A output enable, active high |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_lanes | input | 2 | Port A byte-lane write enables, bit 0 lower half |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_mode | input | 1 | Port A latency: 0 flow-through, 1 pipelined |
| a_rd_data | output | DATA_W | Port A read data, zero when idle |
| a_rd_valid | output | 1 | Port A read data valid |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B asynchronous active-low reset |
| b_en0_n | input | 1 | Port B enable, active low |
| b_en1 | input | 1 | Port B enable, active high |
| b_oe | input | 1 | Port B output enable, active high |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_lanes | input | 2 | Port B byte-lane write enables, bit 0 lower half |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_mode | input | 1 | Port B latency: 0 flow-through, 1 pipelined |
| b_rd_data | output | DATA_W | Port B read data, zero when idle |
| b_rd_valid | output | 1 | Port B read data valid |

## Verification
The bench builds the core with ADDR_W of 6 and DATA_W of 16. The 64-word array can then be filled and read back in full across both ports within a short run. The 8-bit lanes make half-word merges easy to spot. Both ports share one bench clock, which keeps the same-edge cases (read against a write on the other port, and a dual write to one address) exact. It also lets the two ports run in different latency modes side by side.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;
  typedef enum logic {
    OUT_FLOW = 1'b0,
    OUT_PIPE = 1'b1
  } out_mode_e;

  localparam int unsigned LANES = 2;

  function automatic logic port_selected(input logic en0_n, input logic en1);
    return !en0_n && en1;
  endfunction
endpackage

// File: rtl/dpr_xor_bank.sv
`timescale 1ns/1ps
module dpr_xor_bank
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] peer_word,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_word_a,
  output logic [DATA_W-1:0] rd_word_b
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] mem [DEPTH];

  // Store data XOR peer bank so that the XOR of both banks yields data.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_lanes[l]) begin
          mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W] ^ peer_word[l*LANE_W +: LANE_W];
        end
      end
    end
  end

  assign rd_word_a = mem[rd_addr_a];
  assign rd_word_b = mem[rd_addr_b];

  // R6: a disabled lane leaves its half of the bank word untouched
  p_lower_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !wr_lanes[0]) |=>
      (mem[$past(wr_addr)][LANE_W-1:0] == $past(mem[wr_addr][LANE_W-1:0])));

  p_upper_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !wr_lanes[1]) |=>
      (mem[$past(wr_addr)][DATA_W-1:LANE_W] == $past(mem[wr_addr][DATA_W-1:LANE_W])));
endmodule

// File: rtl/dpr_port_ctrl.sv
`timescale 1ns/1ps
module dpr_port_ctrl
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en0_n,
  input  logic              en1,
  input  logic              oe,
  input  logic              we,
  input  logic [LANES-1:0]  lanes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mode,
  input  logic [DATA_W-1:0] look_word,
  output logic              rst_sync_n,
  output logic              req_wr,
  output logic [LANES-1:0]  req_lanes,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rst_pipe;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Input capture stage
  logic              sel_d, sel_q, oe_d, oe_q, we_d, we_q;
  logic [LANES-1:0]  lanes_d, lanes_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [DATA_W-1:0] wdata_d, wdata_q;

  always_comb begin
    sel_d   = port_selected(en0_n, en1);
    oe_d    = oe;
    we_d    = we;
    lanes_d = lanes_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (sel_d) begin
      lanes_d = lanes;
      addr_d  = addr;
      wdata_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q <= 1'b0;
      oe_q  <= 1'b0;
      we_q  <= 1'b0;
    end else begin
      sel_q <= sel_d;
      oe_q  <= oe_d;
      we_q  <= we_d;
    end
  end

  always_ff @(posedge clk) begin
    lanes_q <= lanes_d;
    addr_q  <= addr_d;
    wdata_q <= wdata_d;
  end

  assign req_wr    = sel_q && we_q;
  assign req_lanes = lanes_q;
  assign req_addr  = addr_q;
  assign req_wdata = wdata_q;

  // Flow-through path and optional output register
  logic              ft_valid;
  logic [DATA_W-1:0] ft_data;
  logic              pv_d, pv_q;
  logic [DATA_W-1:0] pd_d, pd_q;

  always_comb begin
    ft_valid = sel_q && oe_q && !we_q;
    ft_data  = ft_valid ? look_word : '0;
    pv_d     = ft_valid;
    pd_d     = ft_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pv_q <= 1'b0;
      pd_q <= '0;
    end else begin
      pv_q <= pv_d;
      pd_q <= pd_d;
    end
  end

  always_comb begin
    if (out_mode_e'(mode) == OUT_PIPE) begin
      rd_valid = pv_q;
      rd_data  = pd_q;
    end else begin
      rd_valid = ft_valid;
      rd_data  = ft_data;
    end
  end

  // R2: flow-through read is valid right after the capturing edge
  p_ft_latency_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (port_selected(en0_n, en1) && oe && !we && mode == OUT_FLOW) |=>
      (mode != OUT_FLOW || rd_valid));

  // R3: pipelined read is valid one edge later
  p_pipe_latency_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (port_selected(en0_n, en1) && oe && !we && mode == OUT_PIPE) |=> ##1
      (mode != OUT_PIPE || rd_valid));

  // R4: a deselected cycle yields no valid flow-through output
  p_deselect_idle_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!port_selected(en0_n, en1) && mode == OUT_FLOW) |=>
      (mode != OUT_FLOW || !rd_valid));

  // R5: pipelined outputs stay idle for the cycle after a deselected capture
  p_pipe_reactivate_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!port_selected(en0_n, en1) && mode == OUT_PIPE) |=> ##1
      (mode != OUT_PIPE || !rd_valid));

  // R7: output enable low at capture gives an idle flow-through output
  p_oe_idle_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!oe && mode == OUT_FLOW) |=> (mode != OUT_FLOW || !rd_valid));

  // R11: idle output carries all zeros
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_valid |-> (rd_data == '0));
endmodule

// File: rtl/dpr_core.sv
`timescale 1ns/1ps
module dpr_core
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 18
) (
  input  logic              a_clk,
  input  logic              a_rst_n,
  input  logic              a_en0_n,
  input  logic              a_en1,
  input  logic              a_oe,
  input  logic              a_we,
  input  logic [1:0]        a_lanes,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_mode,
  output logic [DATA_W-1:0] a_rd_data,
  output logic              a_rd_valid,
  input  logic              b_clk,
  input  logic              b_rst_n,
  input  logic              b_en0_n,
  input  logic              b_en1,
  input  logic              b_oe,
  input  logic              b_we,
  input  logic [1:0]        b_lanes,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_mode,
  output logic [DATA_W-1:0] b_rd_data,
  output logic              b_rd_valid
);
  localparam int unsigned NPORT = 2;

  logic [NPORT-1:0]                   p_clk, p_rst_n, p_en0_n, p_en1, p_oe, p_we, p_mode;
  logic [NPORT-1:0]                   p_rst_sync_n, p_wr, p_valid;
  logic [NPORT-1:0][LANES-1:0]        p_lanes, p_wr_lanes;
  logic [NPORT-1:0][ADDR_W-1:0]       p_addr, p_req_addr;
  logic [NPORT-1:0][DATA_W-1:0]       p_wdata, p_req_wdata, p_look, p_rd_data;
  logic [NPORT-1:0][NPORT-1:0][DATA_W-1:0] bank_rd; // [bank][port]

  assign p_clk   = {b_clk, a_clk};
  assign p_rst_n = {b_rst_n, a_rst_n};
  assign p_en0_n = {b_en0_n, a_en0_n};
  assign p_en1   = {b_en1, a_en1};
  assign p_oe    = {b_oe, a_oe};
  assign p_we    = {b_we, a_we};
  assign p_mode  = {b_mode, a_mode};
  assign p_lanes = {b_lanes, a_lanes};
  assign p_addr  = {b_addr, a_addr};
  assign p_wdata = {b_wdata, a_wdata};

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    dpr_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk        (p_clk[g]),
      .rst_n      (p_rst_n[g]),
      .en0_n      (p_en0_n[g]),
      .en1        (p_en1[g]),
      .oe         (p_oe[g]),
      .we         (p_we[g]),
      .lanes      (p_lanes[g]),
      .addr       (p_addr[g]),
      .wdata      (p_wdata[g]),
      .mode       (p_mode[g]),
      .look_word  (p_look[g]),
      .rst_sync_n (p_rst_sync_n[g]),
      .req_wr     (p_wr[g]),
      .req_lanes  (p_wr_lanes[g]),
      .req_addr   (p_req_addr[g]),
      .req_wdata  (p_req_wdata[g]),
      .rd_data    (p_rd_data[g]),
      .rd_valid   (p_valid[g])
    );

    dpr_xor_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk        (p_clk[g]),
      .rst_sync_n (p_rst_sync_n[g]),
      .wr_en      (p_wr[g]),
      .wr_lanes   (p_wr_lanes[g]),
      .wr_addr    (p_req_addr[g]),
      .wr_data    (p_req_wdata[g]),
      .peer_word  (bank_rd[NPORT-1-g][g]),
      .rd_addr_a  (p_req_addr[0]),
      .rd_addr_b  (p_req_addr[1]),
      .rd_word_a  (bank_rd[g][0]),
      .rd_word_b  (bank_rd[g][1])
    );

    assign p_look[g] = bank_rd[0][g] ^ bank_rd[1][g];
  end

  assign a_rd_data  = p_rd_data[0];
  assign a_rd_valid = p_valid[0];
  assign b_rd_data  = p_rd_data[1];
  assign b_rd_valid = p_valid[1];
endmodule

// File: tb/sim_dpr_core.sv
`timescale 1ns/1ps
module sim_dpr_core;
  localparam int AW = 6;
  localparam int DW = 16;

  typedef struct {
    logic          en0_n, en1, oe, we;
    logic [1:0]    lanes;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } req_t;

  typedef struct {
    int            due;
    bit            skip;
    logic          valid;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_en0_n = 1'b1, a_en1 = 1'b0, a_oe = 1'b0, a_we = 1'b0, a_mode = 1'b0;
  logic b_en0_n = 1'b1, b_en1 = 1'b0, b_oe = 1'b0, b_we = 1'b0, b_mode = 1'b0;
  logic [1:0] a_lanes = '0, b_lanes = '0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rd_data, b_rd_data;
  logic a_rd_valid, b_rd_valid;

  always #2.5 clk = ~clk;

  dpr_core #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .a_clk(clk), .a_rst_n(rst_n), .a_en0_n(a_en0_n), .a_en1(a_en1), .a_oe(a_oe),
    .a_we(a_we), .a_lanes(a_lanes), .a_addr(a_addr), .a_wdata(a_wdata), .a_mode(a_mode),
    .a_rd_data(a_rd_data), .a_rd_valid(a_rd_valid),
    .b_clk(clk), .b_rst_n(rst_n), .b_en0_n(b_en0_n), .b_en1(b_en1), .b_oe(b_oe),
    .b_we(b_we), .b_lanes(b_lanes), .b_addr(b_addr), .b_wdata(b_wdata), .b_mode(b_mode),
    .b_rd_data(b_rd_data), .b_rd_valid(b_rd_valid)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [DW-1:0] model [64];
  bit known [64];
  exp_t qa[$];
  exp_t qb[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input string port, input logic gv,
                       input logic [DW-1:0] gd, input logic ev, input logic [DW-1:0] ed);
    checks++;
    if (gv !== ev || gd !== ed) begin
      failures++;
      $display("FAIL %s port %s: got valid=%0b data=%h, expected valid=%0b data=%h",
               tag, port, gv, gd, ev, ed);
    end
  endtask

  // Monitor: pop the items due this cycle and compare them with the outputs
  always @(negedge clk) begin
    exp_t e;
    while (qa.size() > 0 && qa[0].due <= cyc) begin
      e = qa.pop_front();
      if (!e.skip) check(e.tag, "A", a_rd_valid, a_rd_data, e.valid, e.data);
    end
    while (qb.size() > 0 && qb[0].due <= cyc) begin
      e = qb.pop_front();
      if (!e.skip) check(e.tag, "B", b_rd_valid, b_rd_data, e.valid, e.data);
    end
  end

  function automatic req_t rd(input int a, input logic oe = 1'b1);
    req_t r;
    r.en0_n = 1'b0; r.en1 = 1'b1; r.oe = oe; r.we = 1'b0;
    r.lanes = 2'b00; r.addr = AW'(a); r.wdata = '0;
    return r;
  endfunction

  function automatic req_t wr(input int a, input logic [DW-1:0] d,
                              input logic [1:0] ln = 2'b11, input logic oe = 1'b1);
    req_t r;
    r.en0_n = 1'b0; r.en1 = 1'b1; r.oe = oe; r.we = 1'b1;
    r.lanes = ln; r.addr = AW'(a); r.wdata = d;
    return r;
  endfunction

  function automatic req_t desel(input logic e0n = 1'b1, input logic e1 = 1'b0);
    req_t r;
    r = wr(0, '0);
    r.en0_n = e0n; r.en1 = e1;
    return r;
  endfunction

  function automatic logic [DW-1:0] patt(input int i, input int k);
    return DW'((i * 16'h0137) ^ (k * 16'h5A5B) ^ 16'h0F0F);
  endfunction

  function automatic exp_t make_exp(input req_t r, input logic mode, input string tag);
    exp_t e;
    logic sel;
    sel     = !r.en0_n && r.en1;
    e.valid = sel && r.oe && !r.we;
    e.data  = e.valid ? model[r.addr] : '0;
    e.skip  = e.valid && !known[r.addr];
    e.due   = cyc + (mode ? 2 : 1);
    e.tag   = tag;
    return e;
  endfunction

  task automatic apply_write(input req_t r);
    if (!r.en0_n && r.en1 && r.we) begin
      if (r.lanes[0]) model[r.addr][7:0]  = r.wdata[7:0];
      if (r.lanes[1]) model[r.addr][15:8] = r.wdata[15:8];
      if (r.lanes != 2'b00) known[r.addr] = 1'b1;
    end
  endtask

  // Driver: called at a falling edge; drives both ports for one cycle
  task automatic step(input req_t ra, input req_t rb, input string tag);
    a_en0_n = ra.en0_n; a_en1 = ra.en1; a_oe = ra.oe; a_we = ra.we;
    a_lanes = ra.lanes; a_addr = ra.addr; a_wdata = ra.wdata;
    b_en0_n = rb.en0_n; b_en1 = rb.en1; b_oe = rb.oe; b_we = rb.we;
    b_lanes = rb.lanes; b_addr = rb.addr; b_wdata = rb.wdata;
    qa.push_back(make_exp(ra, a_mode, tag));
    qb.push_back(make_exp(rb, b_mode, tag));
    apply_write(ra);
    apply_write(rb);
    if (!ra.en0_n && ra.en1 && ra.we && !rb.en0_n && rb.en1 && rb.we && ra.addr == rb.addr)
      known[ra.addr] = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle2();
    step(desel(), desel(), "R4 idle");
    step(desel(), desel(), "R4 idle");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      known[i] = 1'b0;
      model[i] = '0;
    end
    repeat (4) @(negedge clk);
    check("R11 reset", "A", a_rd_valid, a_rd_data, 1'b0, '0);
    check("R11 reset", "B", b_rd_valid, b_rd_data, 1'b0, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 after reset", "A", a_rd_valid, a_rd_data, 1'b0, '0);
    check("R11 after reset", "B", b_rd_valid, b_rd_data, 1'b0, '0);

    // R1/R2: port A fills the array, port B reads each word one cycle later
    for (int i = 0; i < 64; i++)
      step(wr(i, patt(i, 1)), (i > 0) ? rd(i - 1) : desel(), "R1 R2 fill and cross read");
    step(desel(), rd(63), "R1 R2 last word");

    // R1: port B overwrites, port A reads back
    for (int i = 0; i < 16; i++)
      step((i > 0) ? rd(i - 1) : desel(), wr(i, patt(i, 2)), "R1 B writes A reads");
    // R1/R8: both ports write distinct words in one cycle; write cycles idle
    for (int i = 0; i < 8; i++)
      step(wr(40 + i, patt(i, 3)), wr(20 + i, patt(i, 4)), "R8 R1 dual write");
    for (int i = 0; i < 8; i++)
      step(rd(20 + i), rd(40 + i), "R1 dual read");

    // R9: same-edge read on the other port sees the old word
    step(wr(5, 16'hBEEF), rd(5), "R9 same-edge old word");
    step(desel(), rd(5), "R9 next-edge new word");

    // R6: lane merges
    step(wr(7, 16'h1122, 2'b11), desel(), "R6 full write");
    step(wr(7, 16'hAAFF, 2'b01), rd(7), "R6 before lower");
    step(wr(7, 16'h33BB, 2'b10), rd(7), "R6 lower only");
    step(wr(7, 16'h5555, 2'b00), rd(7), "R6 upper only");
    step(rd(7), desel(), "R6 no lanes");

    // R7: output enable low
    step(rd(7, 1'b0), rd(5, 1'b0), "R7 read with oe low");
    step(wr(9, 16'hC0DE, 2'b11, 1'b0), desel(), "R7 write with oe low");
    step(desel(), rd(9), "R7 write stored");

    // R4: each deselecting enable combination drops the write
    step(desel(1'b1, 1'b1), desel(1'b0, 1'b0), "R4 deselect write");
    step(desel(1'b1, 1'b0), desel(1'b1, 1'b1), "R4 deselect write");
    begin
      req_t r;
      r = rd(0);
      r.en1 = 1'b0;
      step(r, desel(), "R4 deselected read idle");
    end
    step(rd(0), rd(0), "R4 word 0 unchanged");

    // R3/R5: port A pipelined, port B flow-through
    idle2();
    a_mode = 1'b1;
    step(rd(10), rd(11), "R3 R2 mixed latency");
    step(rd(11), rd(10), "R3 R2 mixed latency");
    step(rd(12), rd(12), "R3 R2 mixed latency");
    step(desel(), desel(), "R5 deselect");
    step(desel(), desel(), "R5 deselect");
    step(rd(13), desel(), "R5 reactivate");
    step(rd(14), desel(), "R5 reactivate");
    step(wr(15, 16'h7E7E), rd(15), "R9 R3 pipe write");
    step(rd(15), desel(), "R3 pipe read after write");
    step(rd(15, 1'b0), desel(), "R7 pipe oe low");
    step(desel(), desel(), "R5 idle");

    // R10: dual write to one address, then a single write defines it
    idle2();
    b_mode = 1'b1;
    step(wr(30, 16'h1111), wr(30, 16'h2222), "R10 collision");
    step(desel(), desel(), "R10 gap");
    step(wr(30, 16'h3C3C), desel(), "R10 single write");
    step(rd(30), rd(30), "R10 defined after single write");
    step(rd(31), rd(29), "R3 both pipelined");

    repeat (4) step(desel(), desel(), "R4 drain");
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule